// File: doc/BRIEF.md
# Software Alert and NMI Control Registers

This block is a small set of control and status registers on a plain 32-bit register bus. Software uses it to raise two classes of alert, recoverable and fatal. Each alert class has a 4-bit multi-bit boolean trigger field. Only the single false code counts as inactive, and every other pattern counts as active, so a flipped bit fails toward raising the alert.

The recoverable trigger produces a one-cycle alert and then returns to the false code by itself. The fatal trigger can only have bits cleared. Once it leaves the false code it can never return to it, so the fatal alert stays asserted until reset.

The block also combines two non-maskable interrupt sources: an alert source and a watchdog source. Each source has an enable bit that software can set but never clear, and a pending bit that hardware sets and software clears. A separate write-1-to-clear register records four hardware error events. Reads are combinational from the addressed register. Writes take effect at the clock edge where both `bus_req_i` and `bus_we_i` are high.

Top module: `sw_alert_nmi_regs`

## Requirements
- R1: After reset, the recoverable trigger (offset 0x00) and the fatal trigger (offset 0x04) read 0x9 (the false code 4'b1001). The NMI enable (0x08), NMI pending (0x0C) and error status (0x10) registers read 0, and all three outputs are low.
- R2: A write to offset 0x00 loads bits 3:0. While the field is not 4'b1001, `alert_recov_o` is high. On the next edge without a write, the field returns to 4'b1001, so a single write gives exactly one cycle of alert. Writing 4'b1001 gives no alert.
- R3: A write to offset 0x04 can only clear bits: the new value is the old value AND bits 3:0 of the write data. Once the field differs from 4'b1001, `alert_fatal_o` stays high, and later writes (including 4'b1111) cannot restore 4'b1001.
- R4: Any 4-bit trigger pattern other than 4'b1001 counts as true, including 4'b0000, 4'b0110 and 4'b1011.
- R5: The NMI enable register (offset 0x08) holds bit 0 for the alert source and bit 1 for the watchdog source. Writing 1 sets a bit, and writing 0 leaves it unchanged.
- R6: The NMI pending register (offset 0x0C) holds bit 0, set by `nmi_alert_set_i`, and bit 1, set by `nmi_wdog_set_i`. Writing 1 to a bit clears it.
- R7: When a hardware set and a software write-1-clear reach the same pending or status bit in the same cycle, the bit ends up set.
- R8: `nmi_o` is high exactly when some source has both its enable bit and its pending bit set.
- R9: The error status register (offset 0x10) is write-1-to-clear, with these bits: bit 0 is set by `err_bus_intg_i`, bit 8 by `err_rsp_intg_i`, bit 9 by `err_core_fatal_i` and bit 10 by `err_core_recov_i`.
- R10: Error status bits 1 to 7 and 11 to 31 always read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 5 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the addressed register (combinational) |
| nmi_alert_set_i | input | 1 | Hardware set of the alert NMI pending bit |
| nmi_wdog_set_i | input | 1 | Hardware set of the watchdog NMI pending bit |
| err_bus_intg_i | input | 1 | Register bus integrity error event |
| err_rsp_intg_i | input | 1 | Fatal response integrity error event |
| err_core_fatal_i | input | 1 | Fatal core internal error event |
| err_core_recov_i | input | 1 | Recoverable core error event |
| alert_recov_o | output | 1 | Recoverable alert request |
| alert_fatal_o | output | 1 | Fatal alert request |
| nmi_o | output | 1 | Non-maskable interrupt request |

## Verification
The trigger fields are written with the true code, the false code, all-zero and a random-looking pattern. This separates a design that decodes only the true code from one that decodes everything except the false code. Fatal writes use a partial clear and then all-ones, which tells clear-only behaviour apart from plain load. The NMI path runs through enabled and masked sources and through a same-cycle set and clear, which separates the OR-of-AND combine and the priority of the hardware set from the alternatives. The status register is written with ones in every reserved bit and with single-bit clears, to show which positions are real.

// File: rtl/sw_alert_nmi_pkg.sv
package sw_alert_nmi_pkg;
   localparam int unsigned MUBI_W = 4;
   localparam logic [MUBI_W-1:0] MUBI_FALSE = 4'b1001;
   localparam logic [MUBI_W-1:0] MUBI_TRUE  = 4'b0110;

   localparam logic [4:0] OFS_RECOV  = 5'h00;
   localparam logic [4:0] OFS_FATAL  = 5'h04;
   localparam logic [4:0] OFS_NMI_EN = 5'h08;
   localparam logic [4:0] OFS_NMI_PD = 5'h0C;
   localparam logic [4:0] OFS_ERR    = 5'h10;

   localparam int unsigned NMI_SRCS = 2;
   localparam int unsigned ERR_EVTS = 4;
   localparam int unsigned ERR_POS [ERR_EVTS] = '{0, 8, 9, 10};
endpackage

// File: rtl/mubi_trigger.sv
module mubi_trigger
   import sw_alert_nmi_pkg::*;
#(
   parameter int unsigned W       = MUBI_W,
   parameter logic [W-1:0] FALSE_C = MUBI_FALSE,
   parameter bit           STICKY  = 1'b0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] val_o,
   output logic         active_o
);
   if (W < 2) begin : g_bad_width
      $error("mubi_trigger: W must be at least 2");
   end

   logic [W-1:0] q;
   assign val_o    = q;
   assign active_o = (q != FALSE_C);

   if (STICKY) begin : g_sticky
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)   q <= FALSE_C;
         else if (wr_i) q <= q & wdata_i;
      end
      p_fatal_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (q != FALSE_C) |=> (q != FALSE_C));
   end else begin : g_selfclr
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)            q <= FALSE_C;
         else if (wr_i)          q <= wdata_i;
         else if (q != FALSE_C)  q <= FALSE_C;
      end
      p_recov_selfclear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (active_o && !wr_i) |=> !active_o);
   end
endmodule

// File: rtl/w1c_bank.sv
module w1c_bank #(
   parameter int unsigned W = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);
   if (W < 1) begin : g_bad_width
      $error("w1c_bank: W must be at least 1");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= '0;
      else         q_o <= (q_o & ~clr_i) | set_i;
   end

   p_hw_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/sw_alert_nmi_regs.sv
module sw_alert_nmi_regs
   import sw_alert_nmi_pkg::*;
#(
   parameter int unsigned DW = 32,
   parameter int unsigned AW = 5
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          bus_req_i,
   input  logic          bus_we_i,
   input  logic [AW-1:0] bus_addr_i,
   input  logic [DW-1:0] bus_wdata_i,
   output logic [DW-1:0] bus_rdata_o,
   input  logic          nmi_alert_set_i,
   input  logic          nmi_wdog_set_i,
   input  logic          err_bus_intg_i,
   input  logic          err_rsp_intg_i,
   input  logic          err_core_fatal_i,
   input  logic          err_core_recov_i,
   output logic          alert_recov_o,
   output logic          alert_fatal_o,
   output logic          nmi_o
);
   if (DW < 11) begin : g_bad_dw
      $error("sw_alert_nmi_regs: DW must hold status bit 10");
   end
   if (AW < 5) begin : g_bad_aw
      $error("sw_alert_nmi_regs: AW must reach offset 0x10");
   end

   logic wr;
   logic wr_recov, wr_fatal, wr_en, wr_pd, wr_err;
   assign wr       = bus_req_i && bus_we_i;
   assign wr_recov = wr && (bus_addr_i == AW'(OFS_RECOV));
   assign wr_fatal = wr && (bus_addr_i == AW'(OFS_FATAL));
   assign wr_en    = wr && (bus_addr_i == AW'(OFS_NMI_EN));
   assign wr_pd    = wr && (bus_addr_i == AW'(OFS_NMI_PD));
   assign wr_err   = wr && (bus_addr_i == AW'(OFS_ERR));

   logic [MUBI_W-1:0] recov_q, fatal_q;

   mubi_trigger #(.STICKY(1'b0)) u_recov (
      .clk_i, .rst_ni, .wr_i(wr_recov), .wdata_i(bus_wdata_i[MUBI_W-1:0]),
      .val_o(recov_q), .active_o(alert_recov_o));

   mubi_trigger #(.STICKY(1'b1)) u_fatal (
      .clk_i, .rst_ni, .wr_i(wr_fatal), .wdata_i(bus_wdata_i[MUBI_W-1:0]),
      .val_o(fatal_q), .active_o(alert_fatal_o));

   // NMI enables: write-1-set only
   logic [NMI_SRCS-1:0] en_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    en_q <= '0;
      else if (wr_en) en_q <= en_q | bus_wdata_i[NMI_SRCS-1:0];
   end

   p_en_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_q != '0) |=> ((en_q & $past(en_q)) == $past(en_q)));

   logic [NMI_SRCS-1:0] pd_q, pd_clr;
   assign pd_clr = wr_pd ? bus_wdata_i[NMI_SRCS-1:0] : '0;

   w1c_bank #(.W(NMI_SRCS)) u_pend (
      .clk_i, .rst_ni, .set_i({nmi_wdog_set_i, nmi_alert_set_i}),
      .clr_i(pd_clr), .q_o(pd_q));

   assign nmi_o = |(en_q & pd_q);

   p_nmi_needs_pend_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pd_q == '0) |-> !nmi_o);

   // Error status: compact storage, scattered bit positions
   logic [ERR_EVTS-1:0] err_set, err_clr, err_q;
   assign err_set = {err_core_recov_i, err_core_fatal_i, err_rsp_intg_i, err_bus_intg_i};
   for (genvar i = 0; i < ERR_EVTS; i++) begin : g_err_map
      assign err_clr[i] = wr_err && bus_wdata_i[ERR_POS[i]];
   end

   w1c_bank #(.W(ERR_EVTS)) u_err (
      .clk_i, .rst_ni, .set_i(err_set), .clr_i(err_clr), .q_o(err_q));

   logic [DW-1:0] err_word;
   always_comb begin
      err_word = '0;
      for (int i = 0; i < ERR_EVTS; i++) err_word[ERR_POS[i]] = err_q[i];
   end

   always_comb begin
      bus_rdata_o = '0;
      unique case (bus_addr_i)
         AW'(OFS_RECOV):  bus_rdata_o[MUBI_W-1:0]   = recov_q;
         AW'(OFS_FATAL):  bus_rdata_o[MUBI_W-1:0]   = fatal_q;
         AW'(OFS_NMI_EN): bus_rdata_o[NMI_SRCS-1:0] = en_q;
         AW'(OFS_NMI_PD): bus_rdata_o[NMI_SRCS-1:0] = pd_q;
         AW'(OFS_ERR):    bus_rdata_o               = err_word;
         default:         bus_rdata_o               = '0;
      endcase
   end

   p_err_reserved_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_addr_i == AW'(OFS_ERR)) |-> ((bus_rdata_o & ~DW'(32'h701)) == '0));

   logic unused_wdata;
   assign unused_wdata = ^bus_wdata_i;
endmodule

// File: tb/sim_sw_alert_nmi_regs.sv
module sim_sw_alert_nmi_regs;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        req, we;
   logic [4:0]  addr;
   logic [31:0] wdata, rdata;
   logic [5:0]  hw;
   logic        a_recov, a_fatal, nmi;

   sw_alert_nmi_regs u0 (
      .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
      .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .nmi_alert_set_i(hw[0]), .nmi_wdog_set_i(hw[1]),
      .err_bus_intg_i(hw[2]), .err_rsp_intg_i(hw[3]),
      .err_core_fatal_i(hw[4]), .err_core_recov_i(hw[5]),
      .alert_recov_o(a_recov), .alert_fatal_o(a_fatal), .nmi_o(nmi));

   // kind: 0 rdata, 1 alert_recov_o, 2 alert_fatal_o, 3 nmi_o
   typedef struct { int kind; logic [31:0] val; string tag; } exp_t;
   exp_t q[$];
   int total = 0, bad = 0;
   bit done = 0;

   task automatic push(int kind, logic [31:0] val, string tag);
      exp_t e;
      e.kind = kind; e.val = val; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic drive(bit r, bit w, logic [4:0] a, logic [31:0] d, logic [5:0] h);
      @(negedge clk);
      req = r; we = w; addr = a; wdata = d; hw = h;
   endtask

   task automatic wr(logic [4:0] a, logic [31:0] d);
      drive(1, 1, a, d, 6'd0);
   endtask

   task automatic rd(logic [4:0] a, logic [31:0] exp, string tag);
      drive(1, 0, a, 32'd0, 6'd0);
      push(0, exp, tag);
   endtask

   // monitor: sample mid low phase, well away from the rising edge
   always @(negedge clk) begin
      #5;
      while (q.size() > 0) begin
         exp_t e;
         logic [31:0] act;
         e = q.pop_front();
         case (e.kind)
            0: act = rdata;
            1: act = {31'd0, a_recov};
            2: act = {31'd0, a_fatal};
            default: act = {31'd0, nmi};
         endcase
         total++;
         if (act !== e.val) begin
            bad++;
            $display("FAIL %s kind=%0d actual=%h expected=%h", e.tag, e.kind, act, e.val);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      req = 0; we = 0; addr = 0; wdata = 0; hw = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(5'h00, 32'h9, "R1 recov reset");
      push(1, 0, "R1 recov out"); push(2, 0, "R1 fatal out"); push(3, 0, "R1 nmi out");
      rd(5'h04, 32'h9, "R1 fatal reset");
      rd(5'h08, 32'h0, "R1 en reset");
      rd(5'h0C, 32'h0, "R1 pend reset");
      rd(5'h10, 32'h0, "R1 err reset");

      // R2 self-clearing recoverable trigger
      wr(5'h00, 32'h6);
      rd(5'h00, 32'h6, "R2 recov loaded"); push(1, 1, "R2 alert pulse");
      rd(5'h00, 32'h9, "R2 recov cleared"); push(1, 0, "R2 pulse ended");
      wr(5'h00, 32'h9);
      rd(5'h00, 32'h9, "R2 false write"); push(1, 0, "R2 no alert on false");
      // R4 other patterns count as true
      wr(5'h00, 32'h0);
      rd(5'h00, 32'h0, "R4 zero loaded"); push(1, 1, "R4 zero is true");
      wr(5'h00, 32'hB);
      rd(5'h00, 32'hB, "R4 1011 loaded"); push(1, 1, "R4 1011 is true");

      // R3 fatal trigger: clear-only, sticky
      wr(5'h04, 32'hF);
      rd(5'h04, 32'h9, "R3 ones keep false"); push(2, 0, "R3 no fatal yet");
      wr(5'h04, 32'h8);
      rd(5'h04, 32'h8, "R3 bit cleared"); push(2, 1, "R3 fatal raised");
      wr(5'h04, 32'hF);
      rd(5'h04, 32'h8, "R3 no restore"); push(2, 1, "R3 fatal held");
      wr(5'h04, 32'h0);
      rd(5'h04, 32'h0, "R4 fatal zero"); push(2, 1, "R4 fatal still true");

      // R5 enable write-1-set
      wr(5'h08, 32'h1);
      rd(5'h08, 32'h1, "R5 alert en set");
      wr(5'h08, 32'h0);
      rd(5'h08, 32'h1, "R5 zero ignored");

      // R6 / R8 pending and combine
      drive(0, 0, 5'h00, 0, 6'b000010);
      rd(5'h0C, 32'h2, "R6 wdog pend"); push(3, 0, "R8 masked wdog");
      drive(0, 0, 5'h00, 0, 6'b000001);
      rd(5'h0C, 32'h3, "R6 alert pend"); push(3, 1, "R8 nmi on");
      wr(5'h0C, 32'h1);
      rd(5'h0C, 32'h2, "R6 w1c bit0"); push(3, 0, "R8 nmi off");
      // R7 collision
      drive(1, 1, 5'h0C, 32'h2, 6'b000010);
      rd(5'h0C, 32'h2, "R7 hw set wins");
      wr(5'h08, 32'h2);
      rd(5'h08, 32'h3, "R5 wdog en set"); push(3, 1, "R8 wdog nmi");

      // R9 / R10 error status
      drive(0, 0, 5'h00, 0, 6'b111100);
      rd(5'h10, 32'h701, "R9 all events");
      wr(5'h10, 32'h100);
      rd(5'h10, 32'h601, "R9 clear bit8");
      wr(5'h10, 32'hFFFF_F8FE);
      rd(5'h10, 32'h601, "R10 reserved ignored");
      drive(1, 1, 5'h10, 32'h200, 6'b010000);
      rd(5'h10, 32'h601, "R7 err set wins");
      wr(5'h10, 32'h601);
      rd(5'h10, 32'h0, "R9 all cleared");

      drive(0, 0, 5'h00, 0, 6'd0);
      repeat (3) @(negedge clk);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule